// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the host side of a three-wire serial EEPROM link: chip select, serial clock, data-in and data-out. A parallel command port accepts an operation code, an 8-bit word address, 16-bit write data and a word count. The block turns these into a framed serial transaction: a start bit, a two-bit opcode, eight address bits, and sixteen data bits when the operation writes data. Read words come back on a parallel output with a strobe. When the command has finished, the block pulses a completion flag.

Every interface time is counted in system clock cycles. `HALF_CLKS` sets each serial clock phase, `GAP_CLKS` sets the minimum chip-select low time, and `POLL_CLKS` bounds the wait for a programming cycle. Data-in only changes while the serial clock is low. Data-out is sampled a full serial period after the rising edge that launched it. After erase or write commands, the block drops chip select, raises it again and watches data-out until the memory reports ready. If the memory never reports ready, an error flag is raised.

Top module: `uwire_host`

## Requirements
- R1: `cmd_ready` is high exactly when the block is idle. A `cmd_start` sampled while it is low has no effect. At the end of every command `done` is high for one cycle, and `cmd_ready` is high in that same cycle.
- R2: Each frame raises chip select and drives data-in high as the start bit. It then sends a two-bit opcode and the address A7 down to A0. The opcodes are 10 for read, 01 for write and 11 for erase.
- R3: Write enable, write disable, write-all and chip erase send opcode 00. Their two address MSBs are 11, 00, 01 and 10 respectively, followed by six zero filler bits. A frame without data has 11 bits.
- R4: Write and write-all follow the address with the 16 write-data bits, MSB first, giving a 27-bit frame.
- R5: A read returns `cmd_count`+1 words from consecutive addresses. Each word is presented on `rdata` with a one-cycle `rvalid`. The read frame has exactly 11+16·(`cmd_count`+1)−1 serial clock rising edges.
- R6: The serial clock toggles only while chip select is high. Each high phase and each low phase lasts at least `HALF_CLKS` cycles. The first rising edge comes at least `HALF_CLKS` cycles after chip select rises.
- R7: Data-in changes only while the serial clock is low. It is therefore stable for `HALF_CLKS` cycles before and after each rising edge.
- R8: Each read bit is sampled `2·HALF_CLKS` cycles after the rising edge that launched it, at the end of the following low phase.
- R9: Chip select stays low for at least `GAP_CLKS` cycles between any two high periods. `done` is raised only after such a gap has elapsed.
- R10: After write, write-all, erase and chip erase, chip select is dropped and raised again, and `done` waits for data-out to read 1. Read, write enable and write disable raise chip select only once.
- R11: If data-out stays 0 for `POLL_CLKS` cycles of polling, the block raises `err_timeout` and ends the command. `err_timeout` clears when the next command is accepted.
- R12: The `cmd_op` codes are 0 read, 1 write, 2 write-all, 3 erase, 4 chip erase and 5 write enable. Codes 6 and 7 both mean write disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Command request, taken when `cmd_ready` is high |
| cmd_op | input | 3 | Operation code (R12) |
| cmd_addr | input | 8 | Word address |
| cmd_wdata | input | 16 | Write data |
| cmd_count | input | CNT_W | Number of read words minus one |
| cmd_ready | output | 1 | Idle, command may be issued |
| done | output | 1 | One-cycle end-of-command pulse |
| rdata | output | 16 | Last read word |
| rvalid | output | 1 | One-cycle strobe for `rdata` |
| err_timeout | output | 1 | Ready poll timed out |
| mw_cs | output | 1 | Chip select to memory |
| mw_sk | output | 1 | Serial clock to memory |
| mw_di | output | 1 | Serial data to memory |
| mw_do | input | 1 | Serial data from memory |

## Verification
Suppose the bit counter or the frame shifter is out of step. The memory then decodes a different opcode or address inside the same frame, and the damage shows as a wrong word on the next read of the affected address, or as a wrong bit or edge count when the frame closes. A sequencing fault in the poll path shows up differently: chip select fails to rise a second time, or `done` arrives before the memory reports ready, within one programming cycle. A timing fault in the phase counter shows at the pins as a serial clock phase or chip-select gap that is too short, and this appears on the very first frame.

// File: rtl/uwire_host.sv
module uwire_host #(
  parameter int HALF_CLKS = 25,
  parameter int GAP_CLKS  = 25,
  parameter int POLL_CLKS = 600000,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic [2:0]       cmd_op,
  input  logic [7:0]       cmd_addr,
  input  logic [15:0]      cmd_wdata,
  input  logic [CNT_W-1:0] cmd_count,
  output logic             cmd_ready,
  output logic             done,
  output logic [15:0]      rdata,
  output logic             rvalid,
  output logic             err_timeout,
  output logic             mw_cs,
  output logic             mw_sk,
  output logic             mw_di,
  input  logic             mw_do
);
  localparam int TMAX = (HALF_CLKS > GAP_CLKS) ? HALF_CLKS : GAP_CLKS;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int PW   = $clog2(POLL_CLKS + 1);
  localparam int RW   = CNT_W + 5;

  typedef enum logic [3:0] {
    S_IDLE, S_CSS, S_HI, S_LO, S_TAIL, S_RLO, S_RHI, S_PGAP, S_PSV, S_POLL, S_GAP
  } st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [26:0]   frame;
  logic [4:0]    nbits;
  logic          prog, rd;
  logic [RW-1:0] rbits;
  logic [15:0]   rsh;
  logic [PW-1:0] pcnt;

  logic [1:0] opc;
  logic [7:0] fa;
  logic       long_f, prog_c, rd_c;

  wire half_end = (tmr == TW'(HALF_CLKS - 1));
  wire gap_end  = (tmr == TW'(GAP_CLKS - 1));
  wire accept   = cmd_start && (st == S_IDLE);
  wire [15:0] rnext = {rsh[14:0], mw_do};

  assign cmd_ready = (st == S_IDLE);

  always_comb begin
    opc = 2'b00; fa = 8'h00; long_f = 1'b0; prog_c = 1'b0; rd_c = 1'b0;
    case (cmd_op)
      3'd0: begin opc = 2'b10; fa = cmd_addr; rd_c = 1'b1; end
      3'd1: begin opc = 2'b01; fa = cmd_addr; long_f = 1'b1; prog_c = 1'b1; end
      3'd2: begin fa = 8'b0100_0000; long_f = 1'b1; prog_c = 1'b1; end
      3'd3: begin opc = 2'b11; fa = cmd_addr; prog_c = 1'b1; end
      3'd4: begin fa = 8'b1000_0000; prog_c = 1'b1; end
      3'd5: fa = 8'b1100_0000;
      default: fa = 8'b0000_0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; frame <= '0; nbits <= '0;
      prog <= 1'b0; rd <= 1'b0; rbits <= '0; rsh <= '0; pcnt <= '0;
      done <= 1'b0; rvalid <= 1'b0; rdata <= '0; err_timeout <= 1'b0;
      mw_cs <= 1'b0; mw_sk <= 1'b0; mw_di <= 1'b0;
    end else begin
      done   <= 1'b0;
      rvalid <= 1'b0;
      tmr    <= tmr + 1'b1;
      case (st)
        S_IDLE: if (accept) begin
          frame       <= {1'b1, opc, fa, cmd_wdata};
          nbits       <= long_f ? 5'd26 : 5'd10;
          prog        <= prog_c;
          rd          <= rd_c;
          rbits       <= {1'b0, cmd_count, 4'b0000} + RW'(16);
          err_timeout <= 1'b0;
          mw_cs       <= 1'b1;
          mw_di       <= 1'b1;
          tmr         <= '0;
          st          <= S_CSS;
        end
        S_CSS, S_LO: if (half_end) begin
          mw_sk <= 1'b1; tmr <= '0; st <= S_HI;
        end
        S_HI: if (half_end) begin
          mw_sk <= 1'b0; tmr <= '0;
          if (nbits != 5'd0) begin
            mw_di <= frame[25];
            frame <= {frame[25:0], 1'b0};
            nbits <= nbits - 1'b1;
            st    <= S_LO;
          end else begin
            mw_di <= 1'b0;
            st    <= rd ? S_RLO : S_TAIL;
          end
        end
        S_RLO: if (half_end) begin
          rsh   <= rnext;
          rbits <= rbits - 1'b1;
          tmr   <= '0;
          if (rbits[3:0] == 4'd1) begin
            rdata  <= rnext;
            rvalid <= 1'b1;
          end
          if (rbits == RW'(1)) begin
            mw_cs <= 1'b0; st <= S_GAP;
          end else begin
            mw_sk <= 1'b1; st <= S_RHI;
          end
        end
        S_RHI: if (half_end) begin
          mw_sk <= 1'b0; tmr <= '0; st <= S_RLO;
        end
        S_TAIL: if (half_end) begin
          mw_cs <= 1'b0; tmr <= '0;
          st    <= prog ? S_PGAP : S_GAP;
        end
        S_PGAP: if (gap_end) begin
          mw_cs <= 1'b1; tmr <= '0; st <= S_PSV;
        end
        S_PSV: if (half_end) begin
          pcnt <= '0; st <= S_POLL;
        end
        S_POLL: begin
          if (mw_do) begin
            mw_cs <= 1'b0; tmr <= '0; st <= S_GAP;
          end else if (pcnt == PW'(POLL_CLKS - 1)) begin
            err_timeout <= 1'b1; mw_cs <= 1'b0; tmr <= '0; st <= S_GAP;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        S_GAP: if (gap_end) begin
          done <= 1'b1; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic          sk_d, cs_d;
  logic [TW-1:0] sk_run, cs_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_d <= 1'b0; cs_d <= 1'b0;
      sk_run <= TW'(TMAX); cs_run <= TW'(TMAX);
    end else begin
      sk_d <= mw_sk;
      cs_d <= mw_cs;
      if (mw_sk != sk_d || mw_cs != cs_d) sk_run <= TW'(1);
      else if (sk_run != TW'(TMAX)) sk_run <= sk_run + 1'b1;
      if (mw_cs != cs_d) cs_run <= TW'(1);
      else if (cs_run != TW'(TMAX)) cs_run <= cs_run + 1'b1;
    end
  end

  // R6
  sk_gated_chk: assert property (@(posedge clk) disable iff (!rst_n) mw_sk |-> mw_cs);
  // R6
  sk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mw_sk) |-> sk_run >= TW'(HALF_CLKS));
  // R6
  sk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mw_sk) |-> sk_run >= TW'(HALF_CLKS));
  // R7
  di_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mw_sk) |-> $stable(mw_di));
  // R7
  di_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_sk && $past(mw_sk)) |-> $stable(mw_di));
  // R9
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mw_cs) |-> cs_run >= TW'(GAP_CLKS));
  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R1
  idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_ready |-> !mw_cs);
endmodule

// File: tb/tb_uwire_host.sv
module tb_uwire_host;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int GAP  = 3;
  localparam int POLL = 60;
  localparam int BUSY = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic [3:0] cmd_count = '0;
  logic cmd_ready, done, rvalid, err_timeout, mw_cs, mw_sk, mw_di, mw_do;
  logic [15:0] rdata;

  int checks = 0, errors = 0, cyc = 0;

  uwire_host #(.HALF_CLKS(HALF), .GAP_CLKS(GAP), .POLL_CLKS(POLL), .CNT_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_count(cmd_count), .cmd_ready(cmd_ready), .done(done),
    .rdata(rdata), .rvalid(rvalid), .err_timeout(err_timeout), .mw_cs(mw_cs),
    .mw_sk(mw_sk), .mw_di(mw_di), .mw_do(mw_do));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // memory model
  logic [15:0] mem [256];
  bit wen_m = 0, stuck = 0, got_start = 0, rd_out = 0;
  int busy_end = 0, nb = 0, rises = 0, frames = 0, cs_rises = 0, last_nb = 0, last_rises = 0;
  logic [26:0] sh = '0;
  logic [7:0] raddr = '0;
  logic [3:0] rbit = '0;
  logic [15:0] rword = '0;

  assign mw_do = mw_cs && (rd_out ? rword[rbit] : (!stuck && cyc >= busy_end));

  always @(posedge mw_cs) begin
    got_start = 0; nb = 0; sh = '0; rd_out = 0; rises = 0; cs_rises++;
  end

  always @(posedge mw_sk) if (mw_cs) begin
    rises++;
    if (rd_out) begin
      if (rbit == 0) begin raddr++; rword = mem[raddr]; rbit = 4'd15; end
      else rbit--;
    end else if (!got_start) begin
      if (mw_di) begin got_start = 1; frames++; end
    end else begin
      sh = {sh[25:0], mw_di}; nb++;
      if (nb == 10 && sh[9:8] == 2'b10) begin
        rd_out = 1; raddr = sh[7:0]; rword = mem[raddr]; rbit = 4'd15;
      end
    end
  end

  always @(negedge mw_cs) begin
    if (got_start) begin
      last_nb = nb; last_rises = rises;
      if (nb == 10) begin
        if (sh[9:8] == 2'b11) begin
          if (wen_m) mem[sh[7:0]] = 16'hFFFF;
          busy_end = cyc + BUSY;
        end else if (sh[9:8] == 2'b00) begin
          case (sh[7:6])
            2'b11: wen_m = 1;
            2'b00: wen_m = 0;
            2'b10: begin
              if (wen_m) for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
              busy_end = cyc + BUSY;
            end
            default: ;
          endcase
        end
      end else if (nb == 26) begin
        if (sh[25:24] == 2'b01 && wen_m) mem[sh[23:16]] = sh[15:0];
        if (sh[25:24] == 2'b00 && sh[23:22] == 2'b01 && wen_m)
          for (int i = 0; i < 256; i++) mem[i] = sh[15:0];
        busy_end = cyc + BUSY;
      end
    end
    rd_out = 0;
  end

  // pin timing monitor
  int srun = 1000, crun = 1000, min_hi = 1000, min_lo = 1000, min_gap = 1000;
  logic psk = 1'b0, pcs = 1'b0;
  always @(negedge clk) begin
    if (mw_cs != pcs) begin
      if (mw_cs && crun < min_gap) min_gap = crun;
      crun = 1;
    end else crun++;
    if (mw_sk != psk) begin
      if (psk) begin if (srun < min_hi) min_hi = srun; end
      else if (srun < min_lo) min_lo = srun;
      srun = 1;
    end else if (mw_cs && !pcs) srun = 1;
    else srun++;
    psk = mw_sk; pcs = mw_cs;
  end

  // read word capture
  logic [15:0] words [16];
  int nw = 0;
  always @(negedge clk) if (rvalid) begin
    if (nw < 16) words[nw] = rdata;
    nw++;
  end

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 16'h0101) ^ 16'hA5C3 ^ (a << 3));
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic [7:0] a, input logic [15:0] d,
                     input logic [3:0] c, input bit poke);
    int n;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_count = c; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk); n++;
      if (poke && n == 5) begin cmd_op = 3'd5; cmd_start = 1'b1; end
      else cmd_start = 1'b0;
    end
    cmd_start = 1'b0;
    if (!done) chk(0, "R1", "done missing", 0, 1);
    else begin
      chk(cmd_ready, "R1", "ready with done", cmd_ready, 1);
      @(negedge clk);
      chk(!done, "R1", "done width", done, 0);
    end
  endtask

  task automatic rd1(input int a, input logic [15:0] exp, input string req);
    nw = 0;
    run(3'd0, 8'(a), 16'h0, 4'd0, 0);
    chk(nw == 1, req, "word count", nw, 1);
    chk(words[0] == exp, req, "read data", words[0], exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int f0, c0;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    repeat (4) @(negedge clk);
    chk(cmd_ready && !mw_cs && !mw_sk && !done && !err_timeout, "R1", "reset state",
        {cmd_ready, mw_cs, mw_sk, done, err_timeout}, 5'b10000);
    rst_n = 1'b1;

    // R3 write enable frame, R10 single CS high, R12 code 5
    f0 = frames; c0 = cs_rises;
    run(3'd5, 8'h00, 16'h0, 4'd0, 0);
    chk(frames == f0 + 1, "R3", "frame count", frames, f0 + 1);
    chk(last_nb == 10, "R3", "bits after start", last_nb, 10);
    chk(cs_rises == c0 + 1, "R10", "cs rises no poll", cs_rises, c0 + 1);
    chk(wen_m == 1, "R12", "write enable decoded", wen_m, 1);

    // R4 write sweep
    for (int a = 0; a < 256; a++) begin
      c0 = cs_rises;
      run(3'd1, 8'(a), pat(a), 4'd0, 0);
      if (a == 0 || a == 255) begin
        chk(last_nb == 26, "R4", "write frame bits", last_nb, 26);
        chk(cs_rises == c0 + 2, "R10", "cs rises with poll", cs_rises, c0 + 2);
        chk(cyc >= busy_end, "R10", "done after ready", cyc, busy_end);
        chk(!err_timeout, "R11", "no timeout", err_timeout, 0);
      end
    end

    // R2 R8 read sweep
    for (int a = 0; a < 256; a++) begin
      rd1(a, pat(a), "R2");
      if (a == 0) chk(last_rises == 26, "R5", "single read rises", last_rises, 26);
    end

    // R5 sequential read with wrap
    nw = 0;
    run(3'd0, 8'd250, 16'h0, 4'd15, 0);
    chk(nw == 16, "R5", "seq word count", nw, 16);
    for (int k = 0; k < 16; k++)
      chk(words[k] == pat((250 + k) % 256), "R8", "seq word", words[k], pat((250 + k) % 256));
    chk(last_rises == 11 + 255, "R5", "seq read rises", last_rises, 266);

    // R2 erase
    run(3'd3, 8'd7, 16'h0, 4'd0, 0);
    rd1(7, 16'hFFFF, "R2");
    rd1(6, pat(6), "R2");

    // R3 write disable blocks write
    run(3'd6, 8'h00, 16'h0, 4'd0, 0);
    chk(wen_m == 0, "R3", "write disable decoded", wen_m, 0);
    run(3'd1, 8'd8, 16'h1234, 4'd0, 0);
    rd1(8, pat(8), "R3");

    // R1 start ignored while busy
    f0 = frames; c0 = cs_rises;
    run(3'd0, 8'd9, 16'h0, 4'd0, 1);
    repeat (20) @(negedge clk);
    chk(frames == f0 + 1, "R1", "frames with busy start", frames, f0 + 1);
    chk(cs_rises == c0 + 1, "R1", "cs rises with busy start", cs_rises, c0 + 1);
    chk(wen_m == 0, "R1", "ignored enable", wen_m, 0);

    // R12 code 7 is write disable too
    run(3'd5, 8'h00, 16'h0, 4'd0, 0);
    run(3'd7, 8'h00, 16'h0, 4'd0, 0);
    chk(wen_m == 0, "R12", "code 7 disable", wen_m, 0);

    // R3 chip erase, R4 write-all
    run(3'd5, 8'h00, 16'h0, 4'd0, 0);
    run(3'd4, 8'h00, 16'h0, 4'd0, 0);
    rd1(0, 16'hFFFF, "R3");
    rd1(100, 16'hFFFF, "R3");
    run(3'd2, 8'h00, 16'h3C96, 4'd0, 0);
    chk(last_nb == 26, "R4", "write-all bits", last_nb, 26);
    rd1(0, 16'h3C96, "R4");
    rd1(77, 16'h3C96, "R4");
    rd1(255, 16'h3C96, "R4");

    // R11 timeout
    stuck = 1;
    run(3'd1, 8'd5, 16'hBEEF, 4'd0, 0);
    chk(err_timeout == 1, "R11", "timeout flag", err_timeout, 1);
    stuck = 0;
    run(3'd5, 8'h00, 16'h0, 4'd0, 0);
    chk(err_timeout == 0, "R11", "flag cleared", err_timeout, 0);

    // R6 R7 R9 pin timing
    chk(min_hi >= HALF, "R6", "sk high min", min_hi, HALF);
    chk(min_lo >= HALF, "R7", "sk low min", min_lo, HALF);
    chk(min_gap >= GAP, "R9", "cs low min", min_gap, GAP);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule